// File: doc/BRIEF.md
# Micro-op Resource Allocator

This block sits between the front-end micro-op queue and the out-of-order backend. Each cycle it looks at a group of up to `LANES` micro-ops (three by default) and, for each one, reserves everything the backend will later need: a reorder-buffer slot, a physical destination register when the micro-op writes one, and a credit in the downstream queue picked by the micro-op's class. Reservation is all-or-nothing per micro-op and strictly oldest first. When a resource runs short for one lane, that lane and every younger lane wait while the older lanes leave. A one-cycle transport register in front of the allocation logic carries the group unchanged from the fetch side to the allocator.

Granted micro-ops leave on the allocation outputs in the same cycle they are granted, tagged with their reorder-buffer index and physical register. The backend returns resources through three paths: retirement count for the reorder buffer, released register identifiers for the free list, and one slot return per cycle for each downstream queue. The free counts of all four resources are visible at the ports.

Top module: `uop_alloc`

## Requirements
- R1: After reset, `rob_free` equals ROB_DEPTH, `preg_free` equals PREG_COUNT, `addr_q_free` and `gen_q_free` equal their queue depths, `alloc_valid` is zero and `in_ready` is 1.
- R2: A group taken at a clock edge (`in_ready` high, any `in_valid` bit set) is presented on the allocation outputs from the next cycle with payload, class bit and destination flag unchanged and in the same lane order.
- R3: Granted lanes receive consecutive reorder-buffer indices modulo ROB_DEPTH, oldest lane first, continuing from the last index handed out; the first index after reset is 0.
- R4: Physical registers are handed out in free-list order only to lanes with `in_has_dst` = 1; after reset the list holds 0 to PREG_COUNT-1 in ascending order, and each released identifier joins the back of the list.
- R5: A lane with class bit 0 takes one address-queue credit and a lane with class bit 1 takes one general-queue credit.
- R6: Lane k is granted only when every older valid lane is granted and the cumulative need of lanes 0..k fits every free count; ungranted lanes move down to lane 0 in the next cycle and `in_ready` stays low until the whole held group is granted. Input lanes must be valid from lane 0 upward.
- R7: Each free count changes at the next edge by its returns minus this cycle's grants; after all resources are returned every count is back at its reset value.
- R8: Returns beyond occupancy have no effect: `retire_cnt` is clipped to the number of occupied reorder-buffer slots, a queue slot return on a full queue is ignored, and a register release with a full free list is ignored.
- R9: The set bits of `alloc_valid` always form a run starting at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | LANES | Valid lanes of the offered group, packed from lane 0 |
| in_has_dst | input | LANES | Lane writes a destination register |
| in_cls | input | LANES | Lane class: 0 address, 1 general |
| in_payload | input | LANES*PAYLOAD_W | Opaque micro-op bits, lane k at bits k*PAYLOAD_W |
| in_ready | output | 1 | Offered group is taken at this edge |
| retire_cnt | input | clog2(LANES+1) | Reorder-buffer slots freed from the head |
| preg_rel_valid | input | 1 | Register release strobe |
| preg_rel_id | input | clog2(PREG_COUNT) | Released register identifier |
| addr_q_rel | input | 1 | One address-queue slot returned |
| gen_q_rel | input | 1 | One general-queue slot returned |
| alloc_valid | output | LANES | Lanes granted this cycle |
| alloc_has_dst | output | LANES | Destination flag of each held lane |
| alloc_cls | output | LANES | Class bit of each held lane |
| alloc_payload | output | LANES*PAYLOAD_W | Payload of each held lane |
| alloc_rob | output | LANES*clog2(ROB_DEPTH) | Reorder-buffer index per granted lane |
| alloc_preg | output | LANES*clog2(PREG_COUNT) | Physical register per granted lane with destination |
| rob_free | output | clog2(ROB_DEPTH+1) | Free reorder-buffer slots |
| preg_free | output | clog2(PREG_COUNT+1) | Free physical registers |
| addr_q_free | output | clog2(ADDR_Q_DEPTH+1) | Free address-queue credits |
| gen_q_free | output | clog2(GEN_Q_DEPTH+1) | Free general-queue credits |

## Verification
A corrupted free count shows at the free-count port one cycle after the edge that wrote it, and changes which lanes get `alloc_valid` in that same cycle, so grant patterns diverge from the arithmetic model right away. A wrong free-list pointer or reorder-buffer tail shows on the very next grant as a register or index that breaks the ascending or release-order sequence. A mistake in the transport register shows as a shifted or duplicated payload on the lanes left behind after a partial grant, visible in the cycle after the stall.

// File: rtl/uop_alloc_pkg.sv
package uop_alloc_pkg;
    typedef enum logic {
        CLS_ADDR = 1'b0,
        CLS_GEN  = 1'b1
    } uop_cls_e;
endpackage

// File: rtl/alloc_drive.sv
module alloc_drive #(
    parameter int LANES = 3,
    parameter int UW    = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            in_valid,
    input  logic [LANES*UW-1:0]         in_bits,
    input  logic [$clog2(LANES+1)-1:0]  take_cnt,
    output logic                        in_ready,
    output logic [LANES-1:0]            pipe_valid,
    output logic [LANES*UW-1:0]         pipe_bits
);
    typedef struct packed {
        logic [LANES-1:0]    v;
        logic [LANES*UW-1:0] b;
    } drive_st_t;

    drive_st_t st_d, st_q;

    always_comb begin
        in_ready = (int'(take_cnt) == $countones(st_q.v));
        st_d     = st_q;
        if (in_ready) begin
            st_d.v = in_valid;
            st_d.b = in_bits;
        end else begin
            st_d.v = st_q.v >> int'(take_cnt);
            st_d.b = st_q.b >> (int'(take_cnt) * UW);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pipe_valid = st_q.v;
    assign pipe_bits  = st_q.b;
endmodule

// File: rtl/alloc_credit.sv
module alloc_credit #(
    parameter int DEPTH = 16,
    parameter int LANES = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(LANES+1)-1:0]  take,
    input  logic [$clog2(LANES+1)-1:0]  give,
    output logic [$clog2(DEPTH+1)-1:0]  free_cnt
);
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [FW-1:0] free;
    } credit_st_t;

    credit_st_t st_d, st_q;
    int occ_c;
    int give_c;

    always_comb begin
        occ_c     = DEPTH - int'(st_q.free);
        give_c    = (int'(give) > occ_c) ? occ_c : int'(give);
        st_d.free = FW'(int'(st_q.free) - int'(take) + give_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.free <= FW'(DEPTH);
        else        st_q      <= st_d;
    end

    assign free_cnt = st_q.free;
endmodule

// File: rtl/alloc_freelist.sv
module alloc_freelist #(
    parameter int N     = 128,
    parameter int LANES = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(LANES+1)-1:0]       pop_cnt,
    input  logic                             rel_valid,
    input  logic [$clog2(N)-1:0]             rel_id,
    output logic [LANES*$clog2(N)-1:0]       heads,
    output logic [$clog2(N+1)-1:0]           free_cnt
);
    localparam int IW = $clog2(N);
    localparam int FW = $clog2(N + 1);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [FW-1:0] cnt;
    } fl_st_t;

    fl_st_t      st_d, st_q;
    logic        push_c;
    logic [IW-1:0] mem_q [N];

    always_comb begin
        push_c    = rel_valid && (int'(st_q.cnt) != N);
        st_d      = st_q;
        st_d.head = st_q.head + IW'(pop_cnt);
        st_d.tail = st_q.tail + IW'(push_c);
        st_d.cnt  = FW'(int'(st_q.cnt) - int'(pop_cnt) + int'(push_c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.head <= '0;
            st_q.tail <= '0;
            st_q.cnt  <= FW'(N);
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= IW'(i);
        end else if (push_c) begin
            mem_q[st_q.tail] <= rel_id;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_head
        assign heads[k*IW +: IW] = mem_q[st_q.head + IW'(k)];
    end

    assign free_cnt = st_q.cnt;
endmodule

// File: rtl/uop_alloc.sv
module uop_alloc
    import uop_alloc_pkg::*;
#(
    parameter int LANES        = 3,
    parameter int PAYLOAD_W    = 16,
    parameter int ROB_DEPTH    = 64,
    parameter int PREG_COUNT   = 128,
    parameter int ADDR_Q_DEPTH = 16,
    parameter int GEN_Q_DEPTH  = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [LANES-1:0]                       in_valid,
    input  logic [LANES-1:0]                       in_has_dst,
    input  logic [LANES-1:0]                       in_cls,
    input  logic [LANES*PAYLOAD_W-1:0]             in_payload,
    output logic                                   in_ready,
    input  logic [$clog2(LANES+1)-1:0]             retire_cnt,
    input  logic                                   preg_rel_valid,
    input  logic [$clog2(PREG_COUNT)-1:0]          preg_rel_id,
    input  logic                                   addr_q_rel,
    input  logic                                   gen_q_rel,
    output logic [LANES-1:0]                       alloc_valid,
    output logic [LANES-1:0]                       alloc_has_dst,
    output logic [LANES-1:0]                       alloc_cls,
    output logic [LANES*PAYLOAD_W-1:0]             alloc_payload,
    output logic [LANES*$clog2(ROB_DEPTH)-1:0]     alloc_rob,
    output logic [LANES*$clog2(PREG_COUNT)-1:0]    alloc_preg,
    output logic [$clog2(ROB_DEPTH+1)-1:0]         rob_free,
    output logic [$clog2(PREG_COUNT+1)-1:0]        preg_free,
    output logic [$clog2(ADDR_Q_DEPTH+1)-1:0]      addr_q_free,
    output logic [$clog2(GEN_Q_DEPTH+1)-1:0]       gen_q_free
);
    localparam int UW = PAYLOAD_W + 2;
    localparam int CW = $clog2(LANES + 1);
    localparam int RW = $clog2(ROB_DEPTH);
    localparam int PW = $clog2(PREG_COUNT);

    typedef struct packed {
        logic [RW-1:0] rob_tail;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    logic [LANES*UW-1:0] in_bits;
    logic [LANES*UW-1:0] pipe_bits;
    logic [LANES-1:0]    pipe_valid;
    logic [LANES-1:0]    lane_dst;
    logic [LANES-1:0]    lane_cls;
    logic [LANES*PW-1:0] fl_heads;
    logic [CW-1:0]       take_c, dst_c, addr_c, gen_c;
    int                  nd, na, ng;
    logic                chain_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign in_bits[k*UW +: UW] = {in_payload[k*PAYLOAD_W +: PAYLOAD_W], in_cls[k], in_has_dst[k]};
        assign lane_dst[k] = pipe_bits[k*UW];
        assign lane_cls[k] = pipe_bits[k*UW + 1];
        assign alloc_payload[k*PAYLOAD_W +: PAYLOAD_W] = pipe_bits[k*UW + 2 +: PAYLOAD_W];
    end

    assign alloc_has_dst = lane_dst;
    assign alloc_cls     = lane_cls;

    alloc_drive #(.LANES(LANES), .UW(UW)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_bits    (in_bits),
        .take_cnt   (take_c),
        .in_ready   (in_ready),
        .pipe_valid (pipe_valid),
        .pipe_bits  (pipe_bits)
    );

    always_comb begin
        nd          = 0;
        na          = 0;
        ng          = 0;
        chain_ok    = 1'b1;
        alloc_valid = '0;
        alloc_rob   = '0;
        alloc_preg  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (chain_ok && pipe_valid[k]
                && (k + 1 <= int'(rob_free))
                && (nd + int'(lane_dst[k]) <= int'(preg_free))
                && (na + int'(lane_cls[k] == CLS_ADDR) <= int'(addr_q_free))
                && (ng + int'(lane_cls[k] == CLS_GEN) <= int'(gen_q_free))) begin
                alloc_valid[k]          = 1'b1;
                alloc_rob[k*RW +: RW]   = st_q.rob_tail + RW'(k);
                if (lane_dst[k]) alloc_preg[k*PW +: PW] = fl_heads[nd*PW +: PW];
                nd = nd + int'(lane_dst[k]);
                na = na + int'(lane_cls[k] == CLS_ADDR);
                ng = ng + int'(lane_cls[k] == CLS_GEN);
            end else begin
                chain_ok = 1'b0;
            end
        end
        take_c        = CW'($countones(alloc_valid));
        dst_c         = CW'(nd);
        addr_c        = CW'(na);
        gen_c         = CW'(ng);
        st_d.rob_tail = st_q.rob_tail + RW'(take_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    alloc_credit #(.DEPTH(ROB_DEPTH), .LANES(LANES)) u_rob_cr (
        .clk(clk), .rst_n(rst_n), .take(take_c), .give(retire_cnt), .free_cnt(rob_free)
    );

    alloc_credit #(.DEPTH(ADDR_Q_DEPTH), .LANES(LANES)) u_addr_cr (
        .clk(clk), .rst_n(rst_n), .take(addr_c), .give(CW'(addr_q_rel)), .free_cnt(addr_q_free)
    );

    alloc_credit #(.DEPTH(GEN_Q_DEPTH), .LANES(LANES)) u_gen_cr (
        .clk(clk), .rst_n(rst_n), .take(gen_c), .give(CW'(gen_q_rel)), .free_cnt(gen_q_free)
    );

    alloc_freelist #(.N(PREG_COUNT), .LANES(LANES)) u_fl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop_cnt   (dst_c),
        .rel_valid (preg_rel_valid),
        .rel_id    (preg_rel_id),
        .heads     (fl_heads),
        .free_cnt  (preg_free)
    );
endmodule

// File: rtl/uop_alloc_chk.sv
module uop_alloc_chk #(
    parameter int LANES        = 3,
    parameter int ROB_DEPTH    = 64,
    parameter int PREG_COUNT   = 128,
    parameter int ADDR_Q_DEPTH = 16,
    parameter int GEN_Q_DEPTH  = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [$clog2(LANES+1)-1:0]          retire_cnt,
    input logic [LANES-1:0]                    alloc_valid,
    input logic [LANES-1:0]                    alloc_has_dst,
    input logic [LANES-1:0]                    alloc_cls,
    input logic [LANES*$clog2(ROB_DEPTH)-1:0]  alloc_rob,
    input logic [$clog2(ROB_DEPTH+1)-1:0]      rob_free,
    input logic [$clog2(PREG_COUNT+1)-1:0]     preg_free,
    input logic [$clog2(ADDR_Q_DEPTH+1)-1:0]   addr_q_free,
    input logic [$clog2(GEN_Q_DEPTH+1)-1:0]    gen_q_free
);
    localparam int RW = $clog2(ROB_DEPTH);

    // R9
    grant_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid & (alloc_valid + LANES'(1))) == '0);

    // R7
    rob_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rob_free) <= ROB_DEPTH);

    // R7
    rob_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid == '0 && retire_cnt == '0) |=> $stable(rob_free));

    // R3
    rob_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid[0] |=> (!alloc_valid[0] ||
            alloc_rob[RW-1:0] == $past(alloc_rob[RW-1:0]) + RW'($countones($past(alloc_valid)))));

    // R4
    preg_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_valid & alloc_has_dst) <= int'(preg_free));

    // R5
    addr_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_valid & ~alloc_cls) <= int'(addr_q_free));

    // R5
    gen_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(alloc_valid & alloc_cls) <= int'(gen_q_free));
endmodule

bind uop_alloc uop_alloc_chk #(
    .LANES(LANES), .ROB_DEPTH(ROB_DEPTH), .PREG_COUNT(PREG_COUNT),
    .ADDR_Q_DEPTH(ADDR_Q_DEPTH), .GEN_Q_DEPTH(GEN_Q_DEPTH)
) u_chk (.*);

// File: tb/uop_alloc_test.sv
module uop_alloc_test;
    localparam int L   = 3;
    localparam int PLW = 8;
    localparam int RD  = 8;
    localparam int PR  = 8;
    localparam int AQD = 4;
    localparam int GQD = 4;
    localparam int RW  = 3;
    localparam int PW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [L-1:0]     in_valid = '0, in_has_dst = '0, in_cls = '0;
    logic [L*PLW-1:0] in_payload = '0;
    logic             in_ready;
    logic [1:0]       retire_cnt = '0;
    logic             preg_rel_valid = 1'b0;
    logic [PW-1:0]    preg_rel_id = '0;
    logic             addr_q_rel = 1'b0, gen_q_rel = 1'b0;
    logic [L-1:0]     alloc_valid, alloc_has_dst, alloc_cls;
    logic [L*PLW-1:0] alloc_payload;
    logic [L*RW-1:0]  alloc_rob;
    logic [L*PW-1:0]  alloc_preg;
    logic [3:0]       rob_free, preg_free;
    logic [2:0]       addr_q_free, gen_q_free;

    uop_alloc #(.LANES(L), .PAYLOAD_W(PLW), .ROB_DEPTH(RD), .PREG_COUNT(PR),
                .ADDR_Q_DEPTH(AQD), .GEN_Q_DEPTH(GQD)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
        .in_cls(in_cls), .in_payload(in_payload), .in_ready(in_ready),
        .retire_cnt(retire_cnt), .preg_rel_valid(preg_rel_valid), .preg_rel_id(preg_rel_id),
        .addr_q_rel(addr_q_rel), .gen_q_rel(gen_q_rel), .alloc_valid(alloc_valid),
        .alloc_has_dst(alloc_has_dst), .alloc_cls(alloc_cls), .alloc_payload(alloc_payload),
        .alloc_rob(alloc_rob), .alloc_preg(alloc_preg), .rob_free(rob_free),
        .preg_free(preg_free), .addr_q_free(addr_q_free), .gen_q_free(gen_q_free)
    );

    int checks = 0, bad = 0;
    bit finished = 0;

    // arithmetic model
    int m_rob, m_aq, m_gq, m_tail;
    int fl[$];
    int inuse[$];
    bit mv[L], md[L], mc[L];
    int mp[L];
    bit eg[L];
    bit e_ready, accepted;
    int e_take, e_na, e_ng;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        int nd, live;
        bit ok;
        nd = 0; e_na = 0; e_ng = 0; e_take = 0; ok = 1; live = 0;
        for (int k = 0; k < L; k++) begin
            eg[k] = 0;
            if (mv[k]) live++;
            if (ok && mv[k] && (k + 1 <= m_rob) && (nd + int'(md[k]) <= fl.size())
                && (e_na + int'(!mc[k]) <= m_aq) && (e_ng + int'(mc[k]) <= m_gq)) begin
                eg[k] = 1;
                chk(int'(alloc_rob[k*RW +: RW]) == (m_tail + k) % RD, "R3", "rob index",
                    int'(alloc_rob[k*RW +: RW]), (m_tail + k) % RD);
                if (md[k])
                    chk(int'(alloc_preg[k*PW +: PW]) == fl[nd], "R4", "physical register",
                        int'(alloc_preg[k*PW +: PW]), fl[nd]);
                chk(int'(alloc_payload[k*PLW +: PLW]) == mp[k], "R2", "payload",
                    int'(alloc_payload[k*PLW +: PLW]), mp[k]);
                chk(alloc_has_dst[k] == md[k] && alloc_cls[k] == mc[k], "R2", "dst/class bits",
                    int'({alloc_has_dst[k], alloc_cls[k]}), int'({md[k], mc[k]}));
                nd += int'(md[k]); e_na += int'(!mc[k]); e_ng += int'(mc[k]); e_take++;
            end else begin
                ok = 0;
            end
            chk(alloc_valid[k] == eg[k], "R6", "grant bit", int'(alloc_valid[k]), int'(eg[k]));
        end
        e_ready = (e_take == live);
        chk(in_ready == e_ready, "R6", "in_ready", int'(in_ready), int'(e_ready));
        chk((alloc_valid & (alloc_valid + 3'd1)) == '0, "R9", "grant run", int'(alloc_valid), 0);
        chk(int'(rob_free) == m_rob, "R7", "rob_free", int'(rob_free), m_rob);
        chk(int'(preg_free) == fl.size(), "R7", "preg_free", int'(preg_free), fl.size());
        chk(int'(addr_q_free) == m_aq, "R5", "addr_q_free", int'(addr_q_free), m_aq);
        chk(int'(gen_q_free) == m_gq, "R5", "gen_q_free", int'(gen_q_free), m_gq);
    endtask

    task automatic update();
        int old_fl, old_rob, old_aq, old_gq, occ;
        old_fl = fl.size(); old_rob = m_rob; old_aq = m_aq; old_gq = m_gq;
        for (int k = 0; k < L; k++)
            if (eg[k] && md[k]) inuse.push_back(fl.pop_front());
        if (preg_rel_valid && old_fl < PR) fl.push_back(int'(preg_rel_id));
        occ = RD - old_rob;
        m_rob = old_rob - e_take + ((int'(retire_cnt) > occ) ? occ : int'(retire_cnt));
        m_aq  = old_aq - e_na + ((addr_q_rel && old_aq < AQD) ? 1 : 0);
        m_gq  = old_gq - e_ng + ((gen_q_rel && old_gq < GQD) ? 1 : 0);
        m_tail = (m_tail + e_take) % RD;
        accepted = e_ready && (in_valid != '0);
        if (e_ready) begin
            for (int k = 0; k < L; k++) begin
                mv[k] = in_valid[k]; md[k] = in_has_dst[k]; mc[k] = in_cls[k];
                mp[k] = int'(in_payload[k*PLW +: PLW]);
            end
        end else begin
            for (int k = 0; k < L; k++) begin
                if (k + e_take < L) begin
                    mv[k] = mv[k+e_take]; md[k] = md[k+e_take];
                    mc[k] = mc[k+e_take]; mp[k] = mp[k+e_take];
                end else begin
                    mv[k] = 0; md[k] = 0; mc[k] = 0; mp[k] = 0;
                end
            end
        end
    endtask

    task automatic run_cycle();
        check_all();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic set_returns(input int c);
        retire_cnt = 2'(c % 4);
        addr_q_rel = (c % 3) != 0;
        gen_q_rel  = (c % 2) == 1;
        preg_rel_valid = 1'b0;
        if ((c % 2) == 0 && inuse.size() > 0) begin
            preg_rel_valid = 1'b1;
            preg_rel_id = PW'(inuse.pop_front());
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired, run hung");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int serial, cyc, guard;
        m_rob = RD; m_aq = AQD; m_gq = GQD; m_tail = 0;
        for (int i = 0; i < PR; i++) fl.push_back(i);
        for (int k = 0; k < L; k++) begin mv[k] = 0; md[k] = 0; mc[k] = 0; mp[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(int'(rob_free) == RD && int'(preg_free) == PR, "R1", "rob/preg free after reset",
            int'({rob_free, preg_free}), int'({4'(RD), 4'(PR)}));
        chk(int'(addr_q_free) == AQD && int'(gen_q_free) == GQD, "R1", "queue free after reset",
            int'({addr_q_free, gen_q_free}), int'({3'(AQD), 3'(GQD)}));
        chk(alloc_valid == '0 && in_ready, "R1", "idle outputs after reset",
            int'({alloc_valid, in_ready}), 1);

        // R8: returns with everything already free have no effect
        retire_cnt = 2'd3; preg_rel_valid = 1'b1; preg_rel_id = 3'd3;
        addr_q_rel = 1'b1; gen_q_rel = 1'b1;
        run_cycle();
        retire_cnt = '0; preg_rel_valid = 1'b0; addr_q_rel = 1'b0; gen_q_rel = 1'b0;
        chk(int'(rob_free) == RD, "R8", "retire on empty rob ignored", int'(rob_free), RD);
        chk(int'(preg_free) == PR, "R8", "release into full list ignored", int'(preg_free), PR);
        chk(int'(addr_q_free) == AQD && int'(gen_q_free) == GQD, "R8", "queue return when full ignored",
            int'({addr_q_free, gen_q_free}), int'({3'(AQD), 3'(GQD)}));

        // sweep every dst/class pattern for each group size
        serial = 0; cyc = 0;
        for (int n = 1; n <= L; n++) begin
            for (int pat = 0; pat < 64; pat++) begin
                in_valid = L'((1 << n) - 1);
                for (int k = 0; k < L; k++) begin
                    in_has_dst[k] = pat[2*k];
                    in_cls[k]     = pat[2*k+1];
                    in_payload[k*PLW +: PLW] = PLW'(serial + k);
                end
                serial += n;
                accepted = 0; guard = 0;
                while (!accepted && guard < 200) begin
                    set_returns(cyc);
                    cyc++; guard++;
                    run_cycle();
                end
            end
        end

        // drain and return all resources
        in_valid = '0;
        for (int i = 0; i < 40; i++) begin
            retire_cnt = 2'd3; addr_q_rel = 1'b1; gen_q_rel = 1'b1;
            preg_rel_valid = 1'b0;
            if (inuse.size() > 0) begin
                preg_rel_valid = 1'b1;
                preg_rel_id = PW'(inuse.pop_front());
            end
            run_cycle();
        end
        retire_cnt = '0; addr_q_rel = 1'b0; gen_q_rel = 1'b0; preg_rel_valid = 1'b0;
        run_cycle();
        chk(int'(rob_free) == RD && int'(preg_free) == PR, "R7", "all rob/preg returned",
            int'({rob_free, preg_free}), int'({4'(RD), 4'(PR)}));
        chk(int'(addr_q_free) == AQD && int'(gen_q_free) == GQD, "R7", "all queue credits returned",
            int'({addr_q_free, gen_q_free}), int'({3'(AQD), 3'(GQD)}));

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule